// File: doc/BRIEF.md
# Serial Bus Slave with Address-Match Wake-Up

This block is the slave end of a two-wire serial bus. One byte-wide shift register handles both directions. Data moves on an external serial clock, which the block samples with its own system clock. The block keeps a programmed slave address. When the bus master signals a bus release, the block marks that the next byte is an address. When that byte completes, the block compares it with the stored address. Depending on the wake-up enable and the interrupt-timing select, the block raises a sticky interrupt request. That request can follow from an address hit, from the release itself, or from every completed byte.

The data line is open drain. The block pulls it low only when it is transmitting a 0 bit. Whatever appears on the line while the block transmits is shifted back into the same register. Firmware can load one byte into both the shift register and the address register, send it, and then read the live coincidence output. A 1 means the transfer was clean and a 0 means a transmit error.

Top module: `sbus_wake_slave`

## Requirements
- R1: After reset, the following are all 0: the shift register, slave address, configuration bits, release flag, interrupt request and output enable.
- R2: A rising serial-clock edge samples `sdi`. The following falling edge shifts that sample into bit 0 and moves the other bits one place toward the MSB. Without a falling edge or a shift-register write, the contents hold. A shift-register write takes priority over a falling edge.
- R3: With transmit enabled (configuration bit 2), `sdo_oe` is 1 exactly while the shift register MSB is 0, and `sdo` is always 0. Each falling edge presents the next bit, MSB first. With transmit disabled, `sdo_oe` is 0.
- R4: A byte completes on the eighth falling edge counted from reset or from the last release strobe. A release strobe restarts the count, which discards a partial byte.
- R5: A release strobe sets the release flag. The first byte completion after it clears the flag.
- R6: With wake-up enabled (configuration bit 0) and timing select (bit 1) clear, the interrupt is set only when the first byte after a release equals the slave address. Later bytes never set it.
- R7: With the timing select set, a release strobe sets the interrupt whatever the wake-up enable is, and byte completions never set it.
- R8: With wake-up and timing select both clear, every completed byte sets the interrupt.
- R9: The interrupt stays set until an `irq_clr` pulse clears it. A set condition in the same cycle as the clear wins.
- R10: `coin` is 1 exactly when the shift register equals the slave address, and it updates continuously.
- R11: After transmitting a byte, the shift register holds the value seen on the wired-AND line. A clean send therefore leaves the loaded byte in place, and a bit the master forces low shows up as a 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data line as seen on the bus |
| sdo | output | 1 | Data driven to the line (always 0) |
| sdo_oe | output | 1 | Pull-low enable for the open-drain line |
| rel_det | input | 1 | Bus-release strobe, one clock |
| wdata | input | DW | Write data for the register ports |
| we_shift | input | 1 | Load the shift register |
| we_addr | input | 1 | Load the slave address |
| we_cfg | input | 1 | Load the config: bit0 wake, bit1 timing select, bit2 transmit |
| irq_clr | input | 1 | Clear the interrupt request |
| shift_q | output | DW | Shift register contents |
| coin | output | 1 | Shift register equals slave address |
| rel_flag | output | 1 | Next completed byte is an address |
| irq | output | 1 | Sticky interrupt request |

## Verification
The vector table runs the mode combinations against matching and mismatching address bytes, with and without a preceding release. This separates a hit from a miss and a first byte from a later byte. It also separates the three interrupt rules: wake-up, timing select and plain per-byte. Directed cases cover the following:
- a release in the middle of a byte, which shows that the bit count restarts;
- an alternating transmit pattern, which checks the pull-low enable bit by bit;
- a master forcing a 0 during transmission, which must clear the coincidence output;
- a set and a clear landing in the same cycle.

// File: rtl/sbus_wake_slave.sv
module sbus_wake_slave #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe,
  input  logic          rel_det,
  input  logic [DW-1:0] wdata,
  input  logic          we_shift,
  input  logic          we_addr,
  input  logic          we_cfg,
  input  logic          irq_clr,
  output logic [DW-1:0] shift_q,
  output logic          coin,
  output logic          rel_flag,
  output logic          irq
);
  localparam int CW = $clog2(DW);

  logic          sck_d, rx_bit, wake, tsel, tx;
  logic [DW-1:0] sr, sa;
  logic [CW-1:0] cnt;

  wire          rise    = sck & ~sck_d;
  wire          fall    = ~sck & sck_d;
  wire          done    = fall && (cnt == CW'(DW - 1));
  wire [DW-1:0] sr_nx   = {sr[DW-2:0], rx_bit};
  wire          hit     = (sr_nx == sa);
  wire          irq_set = (rel_det & tsel) |
                          (done & ~tsel & (~wake | (rel_flag & hit)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_d    <= 1'b0;
      rx_bit   <= 1'b0;
      sr       <= '0;
      sa       <= '0;
      cnt      <= '0;
      wake     <= 1'b0;
      tsel     <= 1'b0;
      tx       <= 1'b0;
      rel_flag <= 1'b0;
      irq      <= 1'b0;
    end else begin
      sck_d <= sck;
      if (rise) rx_bit <= sdi;
      if (we_shift)  sr <= wdata;
      else if (fall) sr <= sr_nx;
      if (we_addr) sa <= wdata;
      if (we_cfg) {tx, tsel, wake} <= wdata[2:0];
      if (rel_det)   cnt <= '0;
      else if (fall) cnt <= cnt + CW'(1);
      if (rel_det)   rel_flag <= 1'b1;
      else if (done) rel_flag <= 1'b0;
      if (irq_set)      irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end

  assign shift_q = sr;
  assign coin    = (sr == sa);
  assign sdo     = 1'b0;
  assign sdo_oe  = tx & ~sr[DW-1];

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fall && !we_shift |=> $stable(shift_q));
  p_byte_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done && !rel_det |=> cnt == '0);
  p_release_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rel_det |=> rel_flag);
  p_first_byte_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rel_flag && done && !rel_det |=> !rel_flag);
  p_later_byte_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && wake && !tsel && !rel_flag && !rel_det && !irq |=> !irq);
  p_timing_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rel_det && tsel |=> irq);
  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);
endmodule

// File: tb/sbus_wake_slave_tb.sv
module sbus_wake_slave_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0, sck = 1'b0, m_bit = 1'b1, rel_det = 1'b0;
  logic [7:0] wdata = '0;
  logic       we_shift = 1'b0, we_addr = 1'b0, we_cfg = 1'b0, irq_clr = 1'b0;
  logic       sdo, sdo_oe, coin, rel_flag, irq;
  logic [7:0] shift_q;
  wire        sdi = m_bit & ~sdo_oe;
  int         total = 0, bad = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  sbus_wake_slave #(.DW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
    .rel_det(rel_det), .wdata(wdata), .we_shift(we_shift), .we_addr(we_addr),
    .we_cfg(we_cfg), .irq_clr(irq_clr), .shift_q(shift_q), .coin(coin),
    .rel_flag(rel_flag), .irq(irq));

  // {wake, tsel, rel, addr[7:0], data[7:0], exp_irq}
  localparam logic [19:0] VEC [8] = '{
    {3'b101, 8'hA5, 8'hA5, 1'b1},
    {3'b101, 8'hA5, 8'hA4, 1'b0},
    {3'b100, 8'h3C, 8'h3C, 1'b0},
    {3'b000, 8'h11, 8'h5A, 1'b1},
    {3'b001, 8'h11, 8'h00, 1'b1},
    {3'b111, 8'h81, 8'h81, 1'b1},
    {3'b110, 8'h81, 8'h81, 1'b0},
    {3'b010, 8'h00, 8'hFF, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int which, input logic [7:0] d);
    wdata = d;
    we_shift = (which == 0); we_addr = (which == 1); we_cfg = (which == 2);
    tick(1);
    we_shift = 0; we_addr = 0; we_cfg = 0;
  endtask

  task automatic pulse_rel();
    rel_det = 1; tick(1); rel_det = 0;
  endtask

  task automatic send_bit(input logic b);
    m_bit = b; sck = 1; tick(2); sck = 0; tick(2); m_bit = 1;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int k = 7; k >= 0; k--) send_bit(b[k]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    chk("R1 shift_q", shift_q, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rel_flag", rel_flag, 0);
    chk("R1 sdo_oe", sdo_oe, 0);
    chk("R10 coin after reset", coin, 1);

    for (int i = 0; i < 8; i++) begin
      logic [19:0] v;
      v = VEC[i];
      irq_clr = 1; tick(1); irq_clr = 0;
      wr(2, {5'b0, 1'b0, v[18], v[19]});
      wr(1, v[16:9]);
      if (v[17]) pulse_rel();
      send_byte(v[8:1]);
      chk($sformatf("R6/R7/R8 irq vec%0d", i), irq, v[0]);
      chk($sformatf("R2 shift_q vec%0d", i), shift_q, v[8:1]);
      chk($sformatf("R5 rel_flag vec%0d", i), rel_flag, 0);
      chk($sformatf("R10 coin vec%0d", i), coin, v[16:9] == v[8:1]);
    end

    // R5 / R7: flag and interrupt directly after the release strobe
    irq_clr = 1; tick(1); irq_clr = 0;
    wr(2, 8'h02);
    pulse_rel();
    chk("R5 rel_flag set", rel_flag, 1);
    chk("R7 irq on release", irq, 1);

    // R4: release mid-byte restarts the count
    irq_clr = 1; tick(1); irq_clr = 0;
    wr(2, 8'h01); wr(1, 8'hC3);
    pulse_rel();
    send_bit(0); send_bit(1); send_bit(1);
    chk("R4 partial byte no irq", irq, 0);
    pulse_rel();
    send_byte(8'hC3);
    chk("R4 irq after restarted byte", irq, 1);
    chk("R4 shift_q", shift_q, 8'hC3);

    // R9: sticky, clear, set wins over clear
    tick(5);
    chk("R9 irq held", irq, 1);
    irq_clr = 1; tick(1); irq_clr = 0;
    chk("R9 irq cleared", irq, 0);
    wr(2, 8'h02);
    rel_det = 1; irq_clr = 1; tick(1); rel_det = 0; irq_clr = 0;
    chk("R9 set beats clear", irq, 1);

    // R10: live comparator through register writes
    wr(0, 8'h5E); wr(1, 8'h5E);
    chk("R10 coin equal", coin, 1);
    wr(1, 8'h5F);
    chk("R10 coin differ", coin, 0);

    // R3 / R11: open-drain transmit, clean loopback
    wr(2, 8'h04); wr(0, 8'h96); wr(1, 8'h96);
    for (int k = 7; k >= 0; k--) begin
      chk($sformatf("R3 sdo_oe bit%0d", k), sdo_oe, ~8'h96 >> k & 1);
      chk("R3 sdo low", sdo, 0);
      send_bit(1);
    end
    chk("R11 clean loopback", shift_q, 8'h96);
    chk("R11 coin clean", coin, 1);

    // R11: master forces the second bit low
    wr(0, 8'hF0); wr(1, 8'hF0);
    send_bit(1); send_bit(0);
    for (int k = 0; k < 6; k++) send_bit(1);
    chk("R11 corrupted loopback", shift_q, 8'hB0);
    chk("R11 coin error", coin, 0);

    wr(2, 8'h00); wr(0, 8'h00);
    chk("R3 oe off when not transmitting", sdo_oe, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule